// File: doc/BRIEF.md
# Command List Sequencer

This block steps through a chain of command blocks held in memory, one block at a time, in the way a processor steps through a program. It is always in one of three states: Idle, Suspended or Active. In Active it presents the pointer of the block it is running on a fetch interface. An external executor runs that block. When the block is finished, the executor returns a one-cycle completion pulse together with the block's link pointer and two bits from the block's command word: a suspend bit and an end-of-list bit.

A host steers the sequencer with four control commands: start, suspend, resume and abort. The sequencer takes one control command at a time. It answers each command with an accept pulse when the command is latched and a done pulse once the command's effect is visible on the state output. The host can also shape the walk through the bits it writes into each block's command word. The safe way to redirect a running list is to suspend, wait for Suspended, and then start.

Top module: `cmd_list_ctrl`

## Requirements
- R1: After a synchronous reset the state output is Idle (code 0), fetch_ptr is 0, and fetch_req, ctl_accept, ctl_done and ctl_busy are all low.
- R2: A control command offered on ctl_valid is latched on a clock edge. ctl_accept is high for exactly the one cycle after that edge. Opcodes: start=0, suspend=1, resume=2, abort=3.
- R3: A start from Idle or Suspended makes the state Active (code 2) and fetch_ptr equal to ctl_ptr one cycle after the accept pulse. ctl_done pulses in that same cycle.
- R4: In Active, a completion with both command-word bits clear moves fetch_ptr to exec_link, and the state stays Active.
- R5: A completion with the end-of-list bit set and the suspend bit clear makes the state Idle and fetch_ptr 0.
- R6: A completion with the suspend bit set makes the state Suspended (code 1). fetch_ptr keeps the pointer of the block that just completed.
- R7: A host suspend while Active takes effect at the next completion. The state becomes Suspended and ctl_done pulses in the same cycle. A host suspend in Idle or Suspended only pulses ctl_done.
- R8: A resume in Suspended makes the state Active, with fetch_ptr equal to the link of the last completed block. A resume in Idle or Active changes nothing and only pulses ctl_done.
- R9: A start while Active is ignored. ctl_busy and ctl_done pulse together, and fetch_ptr is unchanged.
- R10: An abort while Active waits for the current completion and then gives Idle with fetch_ptr 0 and a ctl_done pulse. In Idle or Suspended, an abort gives that result one cycle after the accept pulse.
- R11: While a control command is pending (from its latch edge until its done pulse), ctl_valid is not latched, gets no accept pulse and has no effect.
- R12: fetch_req is high exactly when the state is Active. exec_done has no effect outside Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Host offers a control command |
| ctl_op | input | 2 | Control opcode (start, suspend, resume, abort) |
| ctl_ptr | input | AW | First block pointer for start |
| ctl_accept | output | 1 | One-cycle pulse: command latched |
| ctl_done | output | 1 | One-cycle pulse: command effect visible |
| ctl_busy | output | 1 | Pulse with ctl_done when a start was ignored in Active |
| fetch_req | output | 1 | Block at fetch_ptr is to be executed |
| fetch_ptr | output | AW | Pointer of the associated command block |
| exec_done | input | 1 | One-cycle completion pulse from the executor |
| exec_link | input | AW | Link pointer of the completed block |
| exec_susp | input | 1 | Suspend bit of the completed block's command word |
| exec_eol | input | 1 | End-of-list bit of the completed block's command word |
| state | output | 2 | 0 Idle, 1 Suspended, 2 Active |

## Verification
Every control opcode is applied in every one of the three states. The result in each case is compared with an expected table, which separates immediate effects from effects that wait for a completion. Lists of one to four blocks are walked with computed link pointers. The bench tries all three completion endings (plain, suspend bit, end-of-list), so it can tell a link being followed from a pointer being kept or cleared. Commands offered back to back and stray completions while Idle show that the one-command-at-a-time rule holds and that input outside Active is ignored.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUSP = 2'd1,
    ST_ACT  = 2'd2
  } cu_state_t;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_SUSPEND = 2'd1,
    OP_RESUME  = 2'd2,
    OP_ABORT   = 2'd3
  } ctl_op_t;
endpackage

// File: rtl/cmdl_host_if.sv
// Latches one host control command at a time and pulses accept.
module cmdl_host_if #(
  parameter int AW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_valid,
  input  logic [1:0]             ctl_op,
  input  logic [AW-1:0]          ctl_ptr,
  input  logic                   clr,
  output logic                   pend,
  output cmdl_pkg::ctl_op_t      op,
  output logic [AW-1:0]          ptr,
  output logic                   accept
);
  import cmdl_pkg::*;

  logic take;
  assign take = ctl_valid && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      op     <= OP_START;
      ptr    <= '0;
      accept <= 1'b0;
    end else begin
      accept <= take;
      if (take) begin
        pend <= 1'b1;
        op   <= ctl_op_t'(ctl_op);
        ptr  <= ctl_ptr;
      end else if (clr) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdl_fsm.sv
// Three-state sequencer: list walking plus host command effects.
module cmdl_fsm #(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pend,
  input  cmdl_pkg::ctl_op_t   op,
  input  logic [AW-1:0]       pptr,
  input  logic                exec_done,
  input  logic [AW-1:0]       exec_link,
  input  logic                exec_susp,
  input  logic                exec_eol,
  output logic                clr,
  output logic                done,
  output logic                busy,
  output cmdl_pkg::cu_state_t st,
  output logic [AW-1:0]       ptr
);
  import cmdl_pkg::*;

  cu_state_t     st_n;
  logic [AW-1:0] ptr_n, link_q, link_n;
  logic          done_n, busy_n, held;
  logic          fin;

  assign fin  = (st == ST_ACT) && exec_done;
  // host suspend/abort take over the handling of the running block
  assign held = pend && (op == OP_SUSPEND || op == OP_ABORT);

  always_comb begin
    st_n   = st;
    ptr_n  = ptr;
    link_n = link_q;
    done_n = 1'b0;
    busy_n = 1'b0;
    clr    = 1'b0;

    if (fin && !held) begin
      link_n = exec_link;
      if (exec_susp) begin
        st_n = ST_SUSP;
      end else if (exec_eol) begin
        st_n  = ST_IDLE;
        ptr_n = '0;
      end else begin
        ptr_n = exec_link;
      end
    end

    if (pend) begin
      unique case (op)
        OP_START: begin
          clr    = 1'b1;
          done_n = 1'b1;
          if (st == ST_ACT) begin
            busy_n = 1'b1;
          end else begin
            st_n  = ST_ACT;
            ptr_n = pptr;
          end
        end
        OP_RESUME: begin
          clr    = 1'b1;
          done_n = 1'b1;
          if (st == ST_SUSP) begin
            st_n  = ST_ACT;
            ptr_n = link_q;
          end
        end
        OP_SUSPEND: begin
          if (st != ST_ACT) begin
            clr    = 1'b1;
            done_n = 1'b1;
          end else if (exec_done) begin
            clr    = 1'b1;
            done_n = 1'b1;
            st_n   = ST_SUSP;
            link_n = exec_link;
          end
        end
        OP_ABORT: begin
          if (st != ST_ACT || exec_done) begin
            clr    = 1'b1;
            done_n = 1'b1;
            st_n   = ST_IDLE;
            ptr_n  = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ptr    <= '0;
      link_q <= '0;
      done   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      st     <= st_n;
      ptr    <= ptr_n;
      link_q <= link_n;
      done   <= done_n;
      busy   <= busy_n;
    end
  end
endmodule

// File: rtl/cmd_list_ctrl.sv
module cmd_list_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_valid,
  input  logic [1:0]    ctl_op,
  input  logic [AW-1:0] ctl_ptr,
  output logic          ctl_accept,
  output logic          ctl_done,
  output logic          ctl_busy,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_ptr,
  input  logic          exec_done,
  input  logic [AW-1:0] exec_link,
  input  logic          exec_susp,
  input  logic          exec_eol,
  output logic [1:0]    state
);
  import cmdl_pkg::*;

  logic          pend_q, clr;
  ctl_op_t       op_q;
  logic [AW-1:0] pptr_q;
  cu_state_t     st;

  cmdl_host_if #(.AW(AW)) u_host (
    .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .ctl_op(ctl_op),
    .ctl_ptr(ctl_ptr), .clr(clr), .pend(pend_q), .op(op_q),
    .ptr(pptr_q), .accept(ctl_accept)
  );

  cmdl_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .pend(pend_q), .op(op_q), .pptr(pptr_q),
    .exec_done(exec_done), .exec_link(exec_link), .exec_susp(exec_susp),
    .exec_eol(exec_eol), .clr(clr), .done(ctl_done), .busy(ctl_busy),
    .st(st), .ptr(fetch_ptr)
  );

  assign state     = st;
  assign fetch_req = (st == ST_ACT);
endmodule

// File: rtl/cmdl_chk.sv
module cmdl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_accept,
  input logic          ctl_done,
  input logic          ctl_busy,
  input logic          fetch_req,
  input logic [AW-1:0] fetch_ptr,
  input logic          exec_done,
  input logic [AW-1:0] exec_link,
  input logic          exec_susp,
  input logic          exec_eol,
  input logic [1:0]    state,
  input logic          pend_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (state == 2'd0 && fetch_ptr == '0));
  // R2
  accept_single_chk: assert property (@(posedge clk) disable iff (rst) ctl_accept |=> !ctl_accept);
  // R4
  link_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2 && exec_done && !exec_susp && !exec_eol && !pend_q) |=>
    (state == 2'd2 && fetch_ptr == $past(exec_link)));
  // R5
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst) (state == 2'd0) |-> fetch_ptr == '0);
  // R6
  no_idle_to_susp_chk: assert property (@(posedge clk) disable iff (rst) (state == 2'd0) |=> state != 2'd1);
  // R9
  busy_with_done_chk: assert property (@(posedge clk) disable iff (rst) ctl_busy |-> (ctl_done && state == 2'd2));
  // R11
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (rst) (pend_q && !ctl_done) |=> !ctl_accept);
  // R12
  idle_stray_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && !pend_q) |=> (state == 2'd0 && !fetch_req));
endmodule

bind cmd_list_ctrl cmdl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ctl_accept(ctl_accept), .ctl_done(ctl_done),
  .ctl_busy(ctl_busy), .fetch_req(fetch_req), .fetch_ptr(fetch_ptr),
  .exec_done(exec_done), .exec_link(exec_link), .exec_susp(exec_susp),
  .exec_eol(exec_eol), .state(state), .pend_q(pend_q)
);

// File: tb/tb_cmd_list_ctrl.sv
`timescale 1ns/1ps
module tb_cmd_list_ctrl;
  localparam int AW = 16;
  localparam logic [1:0] S_IDLE = 2'd0, S_SUSP = 2'd1, S_ACT = 2'd2;
  localparam logic [1:0] O_START = 2'd0, O_SUSP = 2'd1, O_RES = 2'd2, O_ABORT = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_valid = 1'b0;
  logic [1:0] ctl_op = '0;
  logic [AW-1:0] ctl_ptr = '0;
  logic ctl_accept, ctl_done, ctl_busy, fetch_req;
  logic [AW-1:0] fetch_ptr;
  logic exec_done = 1'b0, exec_susp = 1'b0, exec_eol = 1'b0;
  logic [AW-1:0] exec_link = '0;
  logic [1:0] state;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cmd_list_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_ptr(ctl_ptr),
    .ctl_accept(ctl_accept), .ctl_done(ctl_done), .ctl_busy(ctl_busy),
    .fetch_req(fetch_req), .fetch_ptr(fetch_ptr), .exec_done(exec_done),
    .exec_link(exec_link), .exec_susp(exec_susp), .exec_eol(exec_eol), .state(state)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [1:0] st, input logic [AW-1:0] p, input logic dn);
    chk(req, "state", 32'(state), 32'(st));
    chk(req, "fetch_ptr", 32'(fetch_ptr), 32'(p));
    chk(req, "fetch_req", 32'(fetch_req), 32'(st == S_ACT));
    chk(req, "done", 32'(ctl_done), 32'(dn));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // offer one command for one cycle; returns just after the latch edge
  task automatic send(input logic [1:0] op, input logic [AW-1:0] p);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = op; ctl_ptr = p;
    @(negedge clk);
    ctl_valid = 1'b0;
    chk("R2", "accept", 32'(ctl_accept), 32'd1);
  endtask

  // one completion pulse; returns with its effect visible
  task automatic fin(input logic [AW-1:0] l, input logic s, input logic e);
    exec_done = 1'b1; exec_link = l; exec_susp = s; exec_eol = e;
    @(negedge clk);
    exec_done = 1'b0; exec_susp = 1'b0; exec_eol = 1'b0;
  endtask

  // drive into a given state: Active at 0x50, Suspended at 0x50 with link 0x60
  task automatic goto(input logic [1:0] st);
    do_reset();
    if (st != S_IDLE) begin
      send(O_START, 16'h0050);
      @(negedge clk);
      if (st == S_SUSP) fin(16'h0060, 1'b1, 1'b0);
    end
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    look("R1", S_IDLE, '0, 1'b0);
    chk("R1", "accept", 32'(ctl_accept), 0);
    chk("R1", "busy", 32'(ctl_busy), 0);

    // R3 / R4 / R5: walk lists of length 1..4
    for (int n = 1; n <= 4; n++) begin
      logic [AW-1:0] base;
      base = AW'(16'h0100 * n);
      send(O_START, base);
      @(negedge clk);
      look("R3", S_ACT, base, 1'b1);
      chk("R2", "accept cleared", 32'(ctl_accept), 0);
      for (int k = 1; k < n; k++) begin
        fin(base + AW'(k * 16), 1'b0, 1'b0);
        look("R4", S_ACT, base + AW'(k * 16), 1'b0);
      end
      fin(16'hBEEF, 1'b0, 1'b1);
      look("R5", S_IDLE, '0, 1'b0);
    end

    // full op x state table
    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 4; o++) begin
        goto(2'(s));
        send(2'(o), 16'h0077);
        @(negedge clk);
        if (s == 2 && (o == 1 || o == 3)) begin
          // R7 / R10: wait for the running block
          look(o == 1 ? "R7" : "R10", S_ACT, 16'h0050, 1'b0);
          fin(16'h0090, 1'b0, 1'b0);
          if (o == 1) look("R7", S_SUSP, 16'h0050, 1'b1);
          else        look("R10", S_IDLE, '0, 1'b1);
        end else begin
          case (o)
            0: if (s == 2) begin
                 look("R9", S_ACT, 16'h0050, 1'b1);
                 chk("R9", "busy", 32'(ctl_busy), 1);
               end else begin
                 look("R3", S_ACT, 16'h0077, 1'b1);
                 chk("R3", "busy", 32'(ctl_busy), 0);
               end
            1: look("R7", s == 0 ? S_IDLE : S_SUSP, s == 0 ? '0 : 16'h0050, 1'b1);
            2: if (s == 1) look("R8", S_ACT, 16'h0060, 1'b1);
               else look("R8", 2'(s), s == 0 ? '0 : 16'h0050, 1'b1);
            default: look("R10", S_IDLE, '0, 1'b1);
          endcase
        end
      end
    end

    // R6: block suspend bit then resume follows the stored link
    do_reset();
    send(O_START, 16'h0200);
    @(negedge clk);
    fin(16'h0210, 1'b1, 1'b0);
    look("R6", S_SUSP, 16'h0200, 1'b0);
    send(O_RES, 16'h0);
    @(negedge clk);
    look("R8", S_ACT, 16'h0210, 1'b1);

    // R11: second command offered while the first is pending
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = O_SUSP; ctl_ptr = '0;
    @(negedge clk);
    chk("R11", "first accept", 32'(ctl_accept), 1);
    ctl_op = O_ABORT;
    @(negedge clk);
    ctl_valid = 1'b0;
    chk("R11", "second accept", 32'(ctl_accept), 0);
    fin(16'h0220, 1'b0, 1'b0);
    look("R11", S_SUSP, 16'h0210, 1'b1);
    repeat (2) @(negedge clk);
    look("R11", S_SUSP, 16'h0210, 1'b0);

    // R12: stray completion outside Active
    fin(16'h0555, 1'b0, 1'b0);
    look("R12", S_SUSP, 16'h0210, 1'b0);
    send(O_ABORT, '0);
    @(negedge clk);
    fin(16'h0666, 1'b1, 1'b0);
    look("R12", S_IDLE, '0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule